// File: doc/BRIEF.md
# Coprocessor Host Handshake Flag Controller

This block produces the three handshake flags that an arithmetic coprocessor presents to its host: an end-of-execution flag, a service-request flag and an error flag. It also holds the error bits of the status register, a busy bit and the service-request enable of the running command, and it places a status byte on its data output when the host reads status. The arithmetic engine and the command decoder sit outside. They reach this block as single-cycle event inputs: command start, command done, the service-request bit of the command, and three error events.

Each flag has its own set and clear rules. The end flag falls on any host access or on a low end acknowledge. The service-request flag follows the per-command enable and clears by itself when a command without that enable completes. The error flag falls when the host reads status. When an internal set event and a clear arrive in the same cycle, the set event wins, so no completion or error is lost. All updates are synchronous, and host strobes are one-cycle enables. The block also reports a reset pulse that was too short for a valid initialization.

Top module: `cop_flag_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `end_flag`, `svc_req` and `err_flag` are low and the status byte reads 0x00.
- R2: After `rst` falls, `rst_short` goes high on the next clock edge if `rst` was high for fewer than MIN_RST_CYCLES (default 5) clock edges. It stays low after a reset long enough. It is cleared while `rst` is high.
- R3: `end_flag` goes high on the edge after `cmd_done`. It holds until a cycle with `host_rd`, `host_wr` or a low `end_ack_n`, and falls on the edge after that cycle. If `cmd_done` is in the same cycle as a clear, `end_flag` is high.
- R4: With `end_ack_n` held low, a one-cycle `cmd_done` gives an `end_flag` pulse exactly one clock wide.
- R5: On `cmd_done`, `svc_req` takes the value of `cmd_svc_bit` on the next edge. A completing command with bit 0 clears it.
- R6: A low `svc_ack_n` clears `svc_req` on the next edge and has no effect on a cycle with `cmd_done`. Otherwise `svc_req` holds.
- R7: Each of `err_div0`, `err_ovf` and `err_unf` sets its own status error bit on the next edge, whether or not the command has completed. `err_flag` is high whenever any error bit is set.
- R8: A status read (`cmd_sel`=1 with `host_rd`=1) clears all error bits on the next edge, except a bit whose error event occurs in that same cycle. A read with `cmd_sel`=0 leaves the error bits unchanged.
- R9: During a status read, `status_out` shows bit7 = busy, bit6 = service-request enable of the current command (`cmd_svc_bit` captured at `cmd_start`), bits 5..3 = 0, bit2 = underflow, bit1 = overflow, bit0 = divide-by-zero, all from before the read's clearing edge. At all other times `status_out` is 0x00.
- R10: Busy is set on the edge after `cmd_start` and cleared on the edge after `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| cmd_sel | input | 1 | 1 = command/status transfer, 0 = data transfer |
| end_ack_n | input | 1 | End acknowledge, active low |
| svc_ack_n | input | 1 | Service acknowledge, active low |
| cmd_start | input | 1 | Command begins |
| cmd_done | input | 1 | Command completes |
| cmd_svc_bit | input | 1 | Service-request bit of the current command |
| err_div0 | input | 1 | Divide-by-zero event |
| err_ovf | input | 1 | Exponent overflow event |
| err_unf | input | 1 | Exponent underflow event |
| status_out | output | 8 | Status byte during a status read, else zero |
| end_flag | output | 1 | End of execution flag |
| svc_req | output | 1 | Service request flag |
| err_flag | output | 1 | Error flag, OR of the error bits |
| rst_short | output | 1 | Previous reset pulse was too short |

## Verification
The bench targets the same-cycle collisions: a completion that arrives with a host access or a service acknowledge, and an error event that arrives with a status read. A design that lets the clear win in those cycles drops a completion or an error the host never sees. The bench holds the end acknowledge low to check for a one-clock pulse. A flag with the wrong priority there would stick high or never appear. It also checks that a data-side read leaves the error bits alone, that a service-bit-0 completion clears a pending request, and that a two-cycle reset is reported as short and a five-cycle reset is not. An off-by-one in the reset counter shows up at exactly that boundary.

// File: rtl/cop_flag_ctrl.sv
module cop_flag_ctrl #(
  parameter int MIN_RST_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic       cmd_sel,
  input  logic       end_ack_n,
  input  logic       svc_ack_n,
  input  logic       cmd_start,
  input  logic       cmd_done,
  input  logic       cmd_svc_bit,
  input  logic       err_div0,
  input  logic       err_ovf,
  input  logic       err_unf,
  output logic [7:0] status_out,
  output logic       end_flag,
  output logic       svc_req,
  output logic       err_flag,
  output logic       rst_short
);
  localparam int CW = $clog2(MIN_RST_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_RST_CYCLES);

  logic [2:0]    err_bits;
  logic [2:0]    err_evt;
  logic          busy, svc_en, rst_q;
  logic [CW-1:0] rst_cnt;
  logic          stat_rd;

  assign stat_rd  = host_rd && cmd_sel;
  assign err_evt  = {err_unf, err_ovf, err_div0};
  assign err_flag = |err_bits;
  assign status_out = stat_rd ? {busy, svc_en, 3'b000, err_bits} : 8'h00;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      rst_short <= 1'b0;
      if (rst_q) rst_cnt <= (rst_cnt == CMAX) ? CMAX : rst_cnt + 1'b1;
      else       rst_cnt <= CW'(1);
    end else if (rst_q) begin
      rst_short <= (rst_cnt < CMAX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      end_flag <= 1'b0;
      svc_req  <= 1'b0;
      err_bits <= 3'b000;
      busy     <= 1'b0;
      svc_en   <= 1'b0;
    end else begin
      if (cmd_done)                               end_flag <= 1'b1;
      else if (host_rd || host_wr || !end_ack_n) end_flag <= 1'b0;

      if (cmd_done)        svc_req <= cmd_svc_bit;
      else if (!svc_ack_n) svc_req <= 1'b0;

      err_bits <= err_evt | (stat_rd ? 3'b000 : err_bits);

      if (cmd_done)       busy <= 1'b0;
      else if (cmd_start) busy <= 1'b1;

      if (cmd_start) svc_en <= cmd_svc_bit;
    end
  end

  a_r3_end_set: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> end_flag);
  a_r3_end_clear: assert property (@(posedge clk) disable iff (rst)
    (!cmd_done && (host_rd || host_wr || !end_ack_n)) |=> !end_flag);
  a_r5_svc_follows_bit: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> (svc_req == $past(cmd_svc_bit)));
  a_r6_svc_ack: assert property (@(posedge clk) disable iff (rst)
    (!cmd_done && !svc_ack_n) |=> !svc_req);
  a_r7_err_set: assert property (@(posedge clk) disable iff (rst)
    (err_div0 || err_ovf || err_unf) |=> err_flag);
  a_r8_err_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(err_div0 || err_ovf || err_unf)) |=> !err_flag);
  a_r10_busy_done: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !status_out[7] || !stat_rd);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |-> (status_out == 8'h00));
endmodule

// File: tb/tb_cop_flag_ctrl.sv
module tb_cop_flag_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_rd = 0, host_wr = 0, cmd_sel = 0;
  logic end_ack_n = 1, svc_ack_n = 1;
  logic cmd_start = 0, cmd_done = 0, cmd_svc_bit = 0;
  logic err_div0 = 0, err_ovf = 0, err_unf = 0;
  logic [7:0] status_out;
  logic end_flag, svc_req, err_flag, rst_short;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  cop_flag_ctrl dut (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr), .cmd_sel(cmd_sel),
    .end_ack_n(end_ack_n), .svc_ack_n(svc_ack_n), .cmd_start(cmd_start),
    .cmd_done(cmd_done), .cmd_svc_bit(cmd_svc_bit), .err_div0(err_div0),
    .err_ovf(err_ovf), .err_unf(err_unf), .status_out(status_out),
    .end_flag(end_flag), .svc_req(svc_req), .err_flag(err_flag), .rst_short(rst_short));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic read_status(output logic [7:0] v);
    host_rd = 1; cmd_sel = 1;
    #1 v = status_out;
    tick();
    host_rd = 0; cmd_sel = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset(6);
    chk("R1 end", {7'd0, end_flag}, 8'd0);
    chk("R1 svc", {7'd0, svc_req}, 8'd0);
    chk("R1 err", {7'd0, err_flag}, 8'd0);
    chk("R2 long reset", {7'd0, rst_short}, 8'd0);
    read_status(v);
    chk("R1 status", v, 8'h00);
  endtask

  task automatic t_short_reset();
    do_reset(2);
    chk("R2 short reset", {7'd0, rst_short}, 8'd1);
    do_reset(5);
    chk("R2 exact reset", {7'd0, rst_short}, 8'd0);
  endtask

  task automatic t_end();
    cmd_done = 1; tick(); cmd_done = 0;
    chk("R3 set", {7'd0, end_flag}, 8'd1);
    tick();
    chk("R3 hold", {7'd0, end_flag}, 8'd1);
    host_wr = 1; tick(); host_wr = 0;
    chk("R3 wr clear", {7'd0, end_flag}, 8'd0);
    cmd_done = 1; host_rd = 1; tick(); cmd_done = 0; host_rd = 0;
    chk("R3 set wins", {7'd0, end_flag}, 8'd1);
    end_ack_n = 0; tick(); end_ack_n = 1;
    chk("R3 ack clear", {7'd0, end_flag}, 8'd0);
  endtask

  task automatic t_end_pulse();
    end_ack_n = 0;
    cmd_done = 1; tick(); cmd_done = 0;
    chk("R4 pulse high", {7'd0, end_flag}, 8'd1);
    tick();
    chk("R4 pulse low", {7'd0, end_flag}, 8'd0);
    end_ack_n = 1;
  endtask

  task automatic t_svc();
    cmd_svc_bit = 1; cmd_done = 1; tick(); cmd_done = 0;
    chk("R5 set", {7'd0, svc_req}, 8'd1);
    tick();
    chk("R6 hold", {7'd0, svc_req}, 8'd1);
    cmd_svc_bit = 0; cmd_done = 1; tick(); cmd_done = 0;
    chk("R5 auto clear", {7'd0, svc_req}, 8'd0);
    cmd_svc_bit = 1; cmd_done = 1; tick(); cmd_done = 0;
    svc_ack_n = 0; tick();
    chk("R6 ack clear", {7'd0, svc_req}, 8'd0);
    cmd_done = 1; tick(); cmd_done = 0;
    chk("R6 set wins", {7'd0, svc_req}, 8'd1);
    tick(); svc_ack_n = 1;
    chk("R6 ack clear again", {7'd0, svc_req}, 8'd0);
    cmd_svc_bit = 0;
    end_ack_n = 0; tick(); end_ack_n = 1;
  endtask

  task automatic t_err();
    logic [7:0] v;
    cmd_svc_bit = 0; cmd_start = 1; tick(); cmd_start = 0;
    err_ovf = 1; tick(); err_ovf = 0;
    chk("R7 err before done", {7'd0, err_flag}, 8'd1);
    read_status(v);
    chk("R9 busy+ovf", v, 8'h82);
    chk("R8 read clear", {7'd0, err_flag}, 8'd0);
    err_unf = 1; read_status(v); err_unf = 0;
    chk("R9 pre-clear value", v, 8'h80);
    chk("R8 set wins", {7'd0, err_flag}, 8'd1);
    read_status(v);
    chk("R9 unf", v, 8'h84);
    cmd_done = 1; tick(); cmd_done = 0;
    read_status(v);
    chk("R10 busy cleared", v, 8'h00);
    end_ack_n = 0; tick(); end_ack_n = 1;
  endtask

  task automatic t_status();
    logic [7:0] v;
    cmd_svc_bit = 1; cmd_start = 1; tick(); cmd_start = 0; cmd_svc_bit = 0;
    err_div0 = 1; tick(); err_div0 = 0;
    host_rd = 1; cmd_sel = 0;
    #1 chk("R9 data read zero", status_out, 8'h00);
    tick(); host_rd = 0;
    chk("R8 data read keeps err", {7'd0, err_flag}, 8'd1);
    chk("R9 idle zero", status_out, 8'h00);
    read_status(v);
    chk("R10 busy+R9 svc_en+div0", v, 8'hC1);
    chk("R7 err cleared", {7'd0, err_flag}, 8'd0);
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_end();
    t_end_pulse();
    t_svc();
    t_err();
    t_status();
    t_short_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule